// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Modulator

This block turns a signed sinusoidal reference sample into a five-level gate code for a multilevel inverter. It builds four triangular carriers, each confined to its own band of the reference range: two bands below zero and two above. It compares the held reference with every carrier and outputs how many carriers the reference is above, offset so that the result is a signed level from -2 to +2. A sample strobe marks the first level code that uses each newly captured reference.

All four carriers come from one up/down triangle counter. A carrier that must run in opposition uses the mirrored count (span minus count) instead of the count itself. A mode input selects which bands are inverted. In disposition mode no band is inverted. In opposition mode the two bands below zero are inverted. In alternate mode every other band is inverted. The carrier period is set at run time as a half-period in clock cycles. The system picks that value so the carrier runs at the wanted multiple of the reference rate, typically 250.

The reference can go beyond the outermost carriers, as happens with a modulation index of 1.1. In that case the level saturates at the extreme code. The mode and the period setting are taken only at a carrier valley, so a carrier period never mixes two settings.

Top module: `lsm_modulator`

## Requirements
- R1: While reset is active and in the first cycle after it, level_o is 0 and strobe_o is 0.
- R2: With half-period setting H (H ≥ 1), the carrier counter takes the values 0, 1, …, H, H-1, …, 1 in turn, so one carrier period lasts 2H cycles. Under a constant setting, strobe_o pulses exactly once every H cycles.
- R3: level_o is a 3-bit two's complement value equal to (number of carriers that the held sample is strictly greater than) minus 2. The band size is B = 2^BAND_W. Band k (k = 0 lowest … 3 highest) spans [(k-2)·B, (k-1)·B]. Its carrier sits at (k-2)·B + c·B/H, where c is the counter value for a normal band and H minus the counter value for an inverted band.
- R4: Mode code 0 (disposition): no band is inverted.
- R5: Mode code 1 (opposition): bands 0 and 1, the ones below zero, are inverted.
- R6: Mode code 2 (alternate): bands 1 and 3 are inverted. Mode code 3 behaves as mode code 0.
- R7: A held sample above +2B gives level +2, and a held sample at or below -2B gives level -2, in every mode and at every counter value.
- R8: mode_i and half_i are captured only in a cycle where the counter sits at a valley (count 0, falling). Changes at other times have no effect until then.
- R9: ref_i is captured only at valleys and peaks (count H, rising). Changes between those points do not affect level_o.
- R10: The level computed from a newly captured sample appears on level_o two cycles after the capture cycle, in the same cycle as the strobe_o pulse for that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | REF_W (16) | Signed reference sample |
| half_i | input | CNT_W (10) | Carrier half-period in cycles, must be ≥ 1 |
| mode_i | input | 2 | Carrier arrangement: 0 disposition, 1 opposition, 2 alternate, 3 as 0 |
| level_o | output | 3 | Signed level code, -2 … +2 |
| strobe_o | output | 1 | One-cycle pulse with the first level of each new sample |

## Verification
The assertions take for granted that half_i is nonzero whenever the counter is at a valley, because a zero span would leave the triangle without a peak. They place no restriction on ref_i or mode_i: any reference value, including full scale, and the unused mode code are legal. The stimulus always draws the half-period from 1 to 12. It changes mode and period at arbitrary cycles, so that captures at valleys and only at valleys are exercised. The reference is drawn from the full signed range as well as from directed values at band edges and beyond the outer bands.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   // Carrier arrangement; code 3 is treated as disposition.
   typedef enum logic [1:0] {
      MD_DISP = 2'd0,
      MD_OPP  = 2'd1,
      MD_ALT  = 2'd2,
      MD_RSV  = 2'd3
   } lsm_mode_e;

endpackage

// File: rtl/lsm_tri_gen.sv
module lsm_tri_gen
   import lsm_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic [1:0]       mode_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] span_o,
   output lsm_mode_e        mode_o,
   output logic             valley_o,
   output logic             peak_o
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("lsm_tri_gen: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] span_q;
   logic             rise_q;
   lsm_mode_e        mode_q;

   assign valley_o = !rise_q && (cnt_q == '0);
   assign peak_o   = rise_q && (cnt_q == span_q);
   assign cnt_o    = cnt_q;
   assign span_o   = span_q;
   assign mode_o   = mode_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         rise_q <= 1'b0;
         span_q <= CNT_W'(1);
         mode_q <= MD_DISP;
      end else begin
         if (valley_o) begin
            span_q <= half_i;
            mode_q <= lsm_mode_e'(mode_i);
         end
         if (rise_q) begin
            if (cnt_q == span_q) begin
               rise_q <= 1'b0;
               cnt_q  <= cnt_q - CNT_W'(1);
            end else begin
               cnt_q  <= cnt_q + CNT_W'(1);
            end
         end else begin
            if (cnt_q == '0) begin
               rise_q <= 1'b1;
               cnt_q  <= CNT_W'(1);
            end else begin
               cnt_q  <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

   // Input assumption: a zero span is never loaded.
   a_r2_span_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
      valley_o |-> (half_i != '0));

   a_r2_within_span: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= span_q);

   a_r2_unit_step: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

   a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !valley_o |=> ($stable(mode_q) && $stable(span_q)));

endmodule

// File: rtl/lsm_band_cmp.sv
module lsm_band_cmp
   import lsm_pkg::*;
#(
   parameter int REF_W  = 16,
   parameter int BAND_W = 12,
   parameter int CNT_W  = 10,
   parameter int NC     = 4,
   parameter int K      = 0
) (
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [CNT_W-1:0]        cnt_i,
   input  logic [CNT_W-1:0]        span_i,
   input  lsm_mode_e               mode_i,
   output logic                    above_o
);

   localparam int PW       = BAND_W + CNT_W + 1;
   localparam int BASE_I   = (K - NC / 2) * (1 << BAND_W);
   localparam logic signed [REF_W:0] BASE   = (REF_W + 1)'(BASE_I);
   localparam logic signed [REF_W:0] BAND_S = (REF_W + 1)'(1 << BAND_W);
   localparam bit INV_OPP  = (K < NC / 2);
   localparam bit INV_ALT  = (K % 2 == 1);

   logic signed [REF_W:0] diff;
   logic [CNT_W-1:0]      pos;
   logic                  inv;
   logic [PW-1:0]         p_ref;
   logic [PW-1:0]         p_car;

   always_comb begin
      unique case (mode_i)
         MD_OPP:  inv = INV_OPP;
         MD_ALT:  inv = INV_ALT;
         default: inv = 1'b0;
      endcase
   end

   assign diff  = $signed({ref_i[REF_W-1], ref_i}) - BASE;
   assign pos   = inv ? (span_i - cnt_i) : cnt_i;
   assign p_ref = PW'(diff[BAND_W:0]) * PW'(span_i);
   assign p_car = {1'b0, pos, BAND_W'(0)};

   // Reference strictly above base + pos*B/span, cross-multiplied by span.
   always_comb begin
      if (diff[REF_W] || (diff == '0)) begin
         above_o = 1'b0;
      end else if (diff > BAND_S) begin
         above_o = 1'b1;
      end else begin
         above_o = (p_ref > p_car);
      end
   end

endmodule

// File: rtl/lsm_modulator.sv
module lsm_modulator
   import lsm_pkg::*;
#(
   parameter int LEVELS = 5,
   parameter int REF_W  = 16,
   parameter int BAND_W = 12,
   parameter int CNT_W  = 10
) (
   input  logic                                   clk_i,
   input  logic                                   rst_i,
   input  logic signed [REF_W-1:0]                ref_i,
   input  logic [CNT_W-1:0]                       half_i,
   input  logic [1:0]                             mode_i,
   output logic signed [$clog2((LEVELS-1)/2+1):0] level_o,
   output logic                                   strobe_o
);

   localparam int NC      = LEVELS - 1;
   localparam int HALF_NC = NC / 2;
   localparam int LVL_W   = $clog2(HALF_NC + 1) + 1;
   localparam logic signed [REF_W-1:0] TOP_S = REF_W'(HALF_NC * (1 << BAND_W));
   localparam logic signed [REF_W-1:0] BOT_S = -TOP_S;

   generate
      if (LEVELS < 3 || LEVELS % 2 == 0) begin : g_bad_levels
         $error("lsm_modulator: LEVELS must be odd and at least 3");
      end
      if (REF_W < BAND_W + $clog2(HALF_NC) + 2) begin : g_bad_ref
         $error("lsm_modulator: REF_W too narrow for the carrier bands");
      end
   endgenerate

   logic [CNT_W-1:0]       cnt;
   logic [CNT_W-1:0]       span;
   lsm_mode_e              mode_q;
   logic                   valley;
   logic                   peak;
   logic signed [REF_W-1:0] ref_q;
   logic                   evt_q;
   logic                   strb_q;
   logic [NC-1:0]          above;
   logic [LVL_W-1:0]       n_above;
   logic signed [LVL_W-1:0] lvl_d;
   logic signed [LVL_W-1:0] lvl_q;

   lsm_tri_gen #(.CNT_W(CNT_W)) i_tri (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .half_i   (half_i),
      .mode_i   (mode_i),
      .cnt_o    (cnt),
      .span_o   (span),
      .mode_o   (mode_q),
      .valley_o (valley),
      .peak_o   (peak)
   );

   for (genvar k = 0; k < NC; k++) begin : g_band
      lsm_band_cmp #(
         .REF_W  (REF_W),
         .BAND_W (BAND_W),
         .CNT_W  (CNT_W),
         .NC     (NC),
         .K      (k)
      ) i_cmp (
         .ref_i   (ref_q),
         .cnt_i   (cnt),
         .span_i  (span),
         .mode_i  (mode_q),
         .above_o (above[k])
      );
   end

   always_comb begin
      n_above = '0;
      for (int k = 0; k < NC; k++) begin
         n_above = n_above + LVL_W'(above[k]);
      end
      lvl_d = $signed(n_above - LVL_W'(HALF_NC));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ref_q  <= '0;
         evt_q  <= 1'b0;
         strb_q <= 1'b0;
         lvl_q  <= '0;
      end else begin
         if (valley || peak) begin
            ref_q <= ref_i;
         end
         evt_q  <= valley || peak;
         strb_q <= evt_q;
         lvl_q  <= lvl_d;
      end
   end

   assign level_o  = lvl_q;
   assign strobe_o = strb_q;

   a_r3_level_span: assert property (@(posedge clk_i) disable iff (rst_i)
      (lvl_q >= -LVL_W'(HALF_NC)) && (lvl_q <= LVL_W'(HALF_NC)));

   a_r7_sat_high: assert property (@(posedge clk_i) disable iff (rst_i)
      (ref_q > TOP_S) |=> (lvl_q == LVL_W'(HALF_NC)));

   a_r7_sat_low: assert property (@(posedge clk_i) disable iff (rst_i)
      (ref_q <= BOT_S) |=> (lvl_q == -LVL_W'(HALF_NC)));

   a_r9_ref_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !(valley || peak) |=> $stable(ref_q));

   a_r10_strobe_src: assert property (@(posedge clk_i) disable iff (rst_i)
      strb_q |-> $past(valley || peak, 2));

endmodule

// File: tb/test_lsm_modulator.sv
module test_lsm_modulator;

   localparam int BW = 4096;

   logic              clk = 1'b0;
   logic              rst_i;
   logic signed [15:0] ref_i;
   logic [9:0]        half_i;
   logic [1:0]        mode_i;
   logic signed [2:0] level_o;
   logic              strobe_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // bench model state (after the latest clock edge)
   int m_cnt, m_dir, m_h, m_mode, m_ref, m_evt, m_strb, m_lvl;
   bit chk_intv = 0;
   int intv_exp = 0;
   int last_strb = -1;

   always #10 clk = ~clk;

   lsm_modulator i_lsm_modulator (
      .clk_i    (clk),
      .rst_i    (rst_i),
      .ref_i    (ref_i),
      .half_i   (half_i),
      .mode_i   (mode_i),
      .level_o  (level_o),
      .strobe_o (strobe_o)
   );

   task automatic check(bit ok, string tag, int act, int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
      end
   endtask

   // Level from the band definitions: count carriers strictly below the sample.
   function automatic int exp_level(int r, int cnt, int h, int md);
      int n = 0;
      for (int k = 0; k < 4; k++) begin
         longint base = longint'(k - 2) * BW;
         bit inv = (md == 1 && k < 2) || (md == 2 && (k % 2) == 1);
         int c = inv ? (h - cnt) : cnt;
         if (longint'(r) * h > base * h + longint'(c) * BW) n++;
      end
      return n - 2;
   endfunction

   task automatic tick(string tag);
      int n_cnt, n_dir, n_h, n_mode, n_ref, n_evt, n_strb, n_lvl;
      bit valley = (m_cnt == 0) && (m_dir == 0);
      bit peak   = (m_cnt == m_h) && (m_dir == 1);
      n_lvl  = exp_level(m_ref, m_cnt, m_h, m_mode);
      n_strb = m_evt;
      n_evt  = valley || peak;
      n_ref  = (valley || peak) ? int'(ref_i) : m_ref;
      n_mode = valley ? ((int'(mode_i) == 3) ? 0 : int'(mode_i)) : m_mode;
      n_h    = valley ? int'(half_i) : m_h;
      if (m_dir == 1) begin
         if (m_cnt == m_h) begin n_dir = 0; n_cnt = m_cnt - 1; end
         else begin n_dir = 1; n_cnt = m_cnt + 1; end
      end else begin
         if (m_cnt == 0) begin n_dir = 1; n_cnt = 1; end
         else begin n_dir = 0; n_cnt = m_cnt - 1; end
      end
      @(negedge clk);
      cyc++;
      m_cnt = n_cnt; m_dir = n_dir; m_h = n_h; m_mode = n_mode;
      m_ref = n_ref; m_evt = n_evt; m_strb = n_strb; m_lvl = n_lvl;
      check(int'(level_o) == m_lvl, {tag, " level"}, int'(level_o), m_lvl);
      check(int'(strobe_o) == m_strb, {tag, " strobe (R10)"}, int'(strobe_o), m_strb);
      if (chk_intv && strobe_o) begin
         if (last_strb >= 0)
            check(cyc - last_strb == intv_exp, "R2 strobe spacing", cyc - last_strb, intv_exp);
         last_strb = cyc;
      end
   endtask

   task automatic hold_ref(int r, int n, string tag);
      ref_i = 16'(r);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic directed_set(string tag);
      int vals[12] = '{0, 1, -1, BW/2, BW, -BW, BW + 7, -BW - 7,
                       2*BW - 1, -2*BW + 1, 3*BW/2, -3*BW/2};
      for (int i = 0; i < 12; i++) hold_ref(vals[i], 40, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd51966));
      rst_i = 1'b1; ref_i = '0; half_i = 10'd8; mode_i = 2'd0;
      m_cnt = 0; m_dir = 0; m_h = 1; m_mode = 0; m_ref = 0;
      m_evt = 0; m_strb = 0; m_lvl = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(level_o == 3'sd0, "R1 reset level", int'(level_o), 0);
         check(strobe_o == 1'b0, "R1 reset strobe", int'(strobe_o), 0);
      end
      rst_i = 1'b0;
      tick("R1 first cycle");
      check(level_o == 3'sd0, "R1 level after reset", int'(level_o), 0);

      mode_i = 2'd0; directed_set("R4 disposition");
      mode_i = 2'd1; directed_set("R5 opposition");
      mode_i = 2'd2; directed_set("R6 alternate");
      mode_i = 2'd3; directed_set("R6 code 3");

      // saturation beyond the outer bands
      for (int md = 0; md < 3; md++) begin
         mode_i = 2'(md);
         hold_ref(32767, 40, "R7 high");
         check(level_o == 3'sd2, "R7 high saturated", int'(level_o), 2);
         hold_ref(2*BW + 1, 40, "R7 high edge");
         hold_ref(-32768, 40, "R7 low");
         check(level_o == -3'sd2, "R7 low saturated", int'(level_o), -2);
         hold_ref(-2*BW, 40, "R7 low edge");
      end

      // strobe spacing and counter period under fixed settings
      foreach (intv_exp_list[j]) ;
      for (int j = 0; j < 3; j++) begin
         int hv = (j == 0) ? 5 : (j == 1) ? 1 : 12;
         half_i = 10'(hv);
         hold_ref(BW/3, 30, "R2 settle");
         intv_exp = hv; last_strb = -1; chk_intv = 1;
         hold_ref(BW/3, 6*hv + 4, "R2 period");
         chk_intv = 0;
      end

      // mode and period changed at arbitrary cycles
      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(0, 3) == 0) mode_i = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 7) == 0) half_i = 10'($urandom_range(1, 12));
         ref_i = 16'($urandom_range(0, 4*BW) - 2*BW);
         tick("R8 config capture");
      end

      // reference toggling every cycle between capture points
      for (int i = 0; i < 1500; i++) begin
         ref_i = 16'($urandom_range(0, 65535));
         if ($urandom_range(0, 31) == 0) mode_i = 2'($urandom_range(0, 2));
         tick("R9 ref hold");
      end

      // broad random mix over the whole level map
      for (int i = 0; i < 2000; i++) begin
         if ($urandom_range(0, 5) == 0) ref_i = 16'($urandom_range(0, 6*BW) - 3*BW);
         if ($urandom_range(0, 63) == 0) half_i = 10'($urandom_range(1, 12));
         if ($urandom_range(0, 63) == 0) mode_i = 2'($urandom_range(0, 3));
         tick("R3 level map");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   int intv_exp_list[1];

endmodule